// File: doc/BRIEF.md
# Single-wire bus slot timing engine

This block produces the time slots of a single-wire open-drain bus: a reset with presence detection, a write of a 0, a write of a 1 and a read. The caller presents one request, which gives a slot kind and a data bit. The engine then runs the whole slot without further input. It pulls the line low by asserting `pull_low`. It releases the line by deasserting `pull_low`, and it never drives the line high. For read and reset slots it samples the synchronized line at a fixed instant. When the slot ends it pulses `done` and presents the sampled value on `rx_bit`.

All phase lengths are written in microseconds. A free divider that restarts at each accepted request turns `CLK_PER_US` clock cycles into one microsecond tick. Each phase length is multiplied by a scale coefficient, which the engine captures when it accepts the request, so slow or heavily loaded buses can use stretched slots. Pad electronics, byte assembly and search algorithms are left to the surrounding logic.

Top module: `owire_slot_engine`

## Requirements
- R1: After reset, `pull_low`, `busy` and `done` are 0 and `rx_bit` is 1.
- R2: A request is accepted in a cycle where `busy` is 0 and `req_valid` is 1. `req_kind` selects the slot: 2'b00 is a write whose value is `req_bit`, 2'b01 is a read, 2'b10 is a reset. A request with 2'b11 starts nothing.
- R3: A write of 1 asserts `pull_low` for 6 us, starting the cycle after acceptance, and then releases the line for 64 us before `done`.
- R4: A write of 0 asserts `pull_low` for 60 us and then releases the line for 10 us before `done`.
- R5: A read asserts `pull_low` for 6 us, releases the line, samples it 9 us after release, and then waits 55 us more before `done`. `rx_bit` shows the sampled level.
- R6: A reset asserts `pull_low` for 500 us, samples the line 70 us after release, and then waits 430 us before `done`. `rx_bit` = 0 means a device answered. `rx_bit` = 1 means no device was seen.
- R7: One microsecond is `CLK_PER_US` cycles. Every phase lasts its length times `scale`, where `scale` is captured at acceptance and a value of 0 counts as 1. Changing `scale` during a slot has no effect on that slot.
- R8: The sample uses `bus_in` as it stood two clock edges before the sampling edge, because the input passes a two-flop synchronizer.
- R9: `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse and appears in the cycle in which `busy` returns to 0. Requests made while `busy` is high are ignored.
- R10: Write slots leave `rx_bit` unchanged.
- R11: `pull_low` is asserted only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Slot request strobe |
| req_kind | input | 2 | Slot kind: 00 write, 01 read, 10 reset, 11 none |
| req_bit | input | 1 | Data value for a write slot |
| scale | input | SCALE_W | Delay multiplier, 0 treated as 1 |
| bus_in | input | 1 | Raw line level from the pad |
| pull_low | output | 1 | Pull-down enable to the pad |
| busy | output | 1 | Slot in progress |
| done | output | 1 | One-cycle end-of-slot pulse |
| rx_bit | output | 1 | Last sampled read value or presence result |

## Verification
The hardest point to reach is the exact sampling instant, because the synchronizer delay and the tick alignment both move it. The bench holds the line at one level up to the negedge two cycles before the expected sampling edge and inverts it from the next negedge on. A sample taken one cycle early or late then returns the inverted value. This is repeated for both line levels, for reads and resets, and over several scale values up to the widest. Separate runs change `scale` and issue a second request in the middle of a slot. In these runs the measured phase lengths must still match the values computed when the slot was accepted.

// File: rtl/owire_slot_pkg.sv
package owire_slot_pkg;

   typedef enum logic [1:0] {
      K_WRITE = 2'b00,
      K_READ  = 2'b01,
      K_RESET = 2'b10,
      K_NONE  = 2'b11
   } req_kind_e;

   typedef enum logic [1:0] {
      SL_WR0,
      SL_WR1,
      SL_READ,
      SL_RESET
   } slot_e;

   // Longest single phase in microseconds.
   localparam int unsigned LEN_MAX = 500;

   // Phase 0: line pulled low; phase 1: released up to sample; phase 2: after sample.
   function automatic int unsigned slot_len(slot_e s, int unsigned ph);
      int unsigned v;
      v = 0;
      unique case (s)
         SL_WR1:   v = (ph == 0) ? 6   : (ph == 1) ? 64 : 0;
         SL_WR0:   v = (ph == 0) ? 60  : (ph == 1) ? 10 : 0;
         SL_READ:  v = (ph == 0) ? 6   : (ph == 1) ? 9  : 55;
         SL_RESET: v = (ph == 0) ? 500 : (ph == 1) ? 70 : 430;
         default:  v = 0;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/owire_us_tick.sv
module owire_us_tick #(
   parameter int CLK_PER_US = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

   generate
      if (CLK_PER_US < 1) begin : g_bad_div
         $error("CLK_PER_US must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
      end else if (clr || div_q == DIV_LAST) begin
         div_q <= '0;
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign tick = (div_q == DIV_LAST);

   generate
      if (CLK_PER_US > 1) begin : g_gap_chk
         // R7: ticks are separated by whole microsecond periods
         p_tick_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/owire_in_sync.sv
module owire_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[0] <= 1'b1;
      else        sh_q[0] <= d;
   end

   generate
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q[i] <= 1'b1;
            else        sh_q[i] <= sh_q[i-1];
         end
      end
   endgenerate

   assign q = sh_q[STAGES-1];

endmodule

// File: rtl/owire_slot_seq.sv
module owire_slot_seq
   import owire_slot_pkg::*;
#(
   parameter int SCALE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   input  logic               req_bit,
   input  logic [SCALE_W-1:0] scale,
   input  logic               samp_in,
   output logic               tick_clr,
   output logic               pull_low,
   output logic               busy,
   output logic               done,
   output logic               rx_bit
);
   localparam int CNT_W = $clog2(LEN_MAX * (2 ** SCALE_W)) + 1;

   generate
      if (SCALE_W < 1 || SCALE_W > 16) begin : g_bad_scale
         $error("SCALE_W must be between 1 and 16");
      end
   endgenerate

   typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_WAIT, PH_TAIL} phase_e;

   phase_e             ph_q;
   slot_e              slot_q;
   slot_e              slot_new;
   logic [SCALE_W-1:0] scl_q;
   logic [SCALE_W-1:0] scl_eff;
   logic [CNT_W-1:0]   cnt_q;
   logic               pull_q;
   logic               done_q;
   logic               rx_q;
   logic               accept;
   logic               last_tick;

   function automatic logic [CNT_W-1:0] span(int unsigned len, logic [SCALE_W-1:0] s);
      return CNT_W'(len * 32'(s) - 1);
   endfunction

   always_comb begin
      unique case (req_kind)
         2'b00:   slot_new = req_bit ? SL_WR1 : SL_WR0;
         2'b01:   slot_new = SL_READ;
         default: slot_new = SL_RESET;
      endcase
   end

   assign scl_eff   = (scale == '0) ? SCALE_W'(1) : scale;
   assign accept    = (ph_q == PH_IDLE) && req_valid && (req_kind != 2'b11);
   assign last_tick = tick && (cnt_q == '0);
   assign tick_clr  = accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         slot_q <= SL_WR1;
         scl_q  <= SCALE_W'(1);
         cnt_q  <= '0;
         pull_q <= 1'b0;
         done_q <= 1'b0;
         rx_q   <= 1'b1;
      end else begin
         done_q <= 1'b0;
         unique case (ph_q)
            PH_IDLE: begin
               if (accept) begin
                  slot_q <= slot_new;
                  scl_q  <= scl_eff;
                  cnt_q  <= span(slot_len(slot_new, 0), scl_eff);
                  pull_q <= 1'b1;
                  ph_q   <= PH_LOW;
               end
            end
            PH_LOW: begin
               if (last_tick) begin
                  pull_q <= 1'b0;
                  cnt_q  <= span(slot_len(slot_q, 1), scl_q);
                  ph_q   <= PH_WAIT;
               end else if (tick) begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_WAIT: begin
               if (last_tick) begin
                  if (slot_q == SL_READ || slot_q == SL_RESET) rx_q <= samp_in;
                  if (slot_len(slot_q, 2) == 0) begin
                     done_q <= 1'b1;
                     ph_q   <= PH_IDLE;
                  end else begin
                     cnt_q <= span(slot_len(slot_q, 2), scl_q);
                     ph_q  <= PH_TAIL;
                  end
               end else if (tick) begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (last_tick) begin
                  done_q <= 1'b1;
                  ph_q   <= PH_IDLE;
               end else if (tick) begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
         endcase
      end
   end

   assign pull_low = pull_q;
   assign busy     = (ph_q != PH_IDLE);
   assign done     = done_q;
   assign rx_bit   = rx_q;

   // R11: the pad is only pulled while a slot runs
   p_pull_in_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pull_low |-> busy);
   // R9: end-of-slot strobe lasts one cycle
   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R9: strobe coincides with return to idle
   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R2: accepted request pulls the line on the next cycle
   p_start_pull_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> (busy && pull_low));
   // R7: captured slot and scale hold for the whole slot
   p_slot_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(slot_q) && $stable(scl_q)));

endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine #(
   parameter int CLK_PER_US  = 100,
   parameter int SCALE_W     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [1:0]         req_kind,
   input  logic               req_bit,
   input  logic [SCALE_W-1:0] scale,
   input  logic               bus_in,
   output logic               pull_low,
   output logic               busy,
   output logic               done,
   output logic               rx_bit
);
   logic tick;
   logic tick_clr;
   logic samp;

   owire_us_tick #(.CLK_PER_US(CLK_PER_US)) tick_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tick_clr),
      .tick  (tick)
   );

   owire_in_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_in),
      .q     (samp)
   );

   owire_slot_seq #(.SCALE_W(SCALE_W)) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .req_valid (req_valid),
      .req_kind  (req_kind),
      .req_bit   (req_bit),
      .scale     (scale),
      .samp_in   (samp),
      .tick_clr  (tick_clr),
      .pull_low  (pull_low),
      .busy      (busy),
      .done      (done),
      .rx_bit    (rx_bit)
   );

endmodule

// File: tb/owire_slot_engine_tb.sv
module owire_slot_engine_tb_top;
   localparam int CPU = 2;
   localparam int SW  = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = 2'b00;
   logic          req_bit = 1'b0;
   logic [SW-1:0] scale = '0;
   logic          bus_in = 1'b1;
   logic          pull_low, busy, done, rx_bit;

   int checks = 0;
   int fails  = 0;
   logic exp_rx = 1'b1;

   always #2.5 clk = ~clk;

   owire_slot_engine #(.CLK_PER_US(CPU), .SCALE_W(SW), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .req_bit(req_bit), .scale(scale), .bus_in(bus_in), .pull_low(pull_low),
      .busy(busy), .done(done), .rx_bit(rx_bit)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int plen(input logic [1:0] kind, input logic b, input int ph);
      int t[3];
      if (kind == 2'b01)      t = '{6, 9, 55};
      else if (kind == 2'b10) t = '{500, 70, 430};
      else if (b)             t = '{6, 64, 0};
      else                    t = '{60, 10, 0};
      return t[ph];
   endfunction

   // mode 0 plain, 1 second request mid-slot, 2 scale change mid-slot
   task automatic run_slot(input logic [1:0] kind, input logic b, input int scl,
                           input logic busv, input int mode, input string req);
      int s, lo, tot, p, k, lowc;
      logic samples;
      s = (scl == 0) ? 1 : scl;
      lo  = plen(kind, b, 0) * s * CPU;
      p   = (plen(kind, b, 0) + plen(kind, b, 1)) * s * CPU;
      tot = p + plen(kind, b, 2) * s * CPU;
      samples = (kind == 2'b01 || kind == 2'b10);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_bit = b; scale = SW'(scl); bus_in = busv;
      @(negedge clk);
      req_valid = 1'b0;
      k = 1; lowc = 0;
      while (!done && k < tot + 50) begin
         if (pull_low) lowc++;
         if (k == 1) check(pull_low == 1'b1, {req, " R2 pull starts after accept"}, pull_low, 1);
         req_valid = (mode == 1 && k == 5);
         if (mode == 1 && k == 5) req_kind = 2'b10;
         if (mode == 2 && k == 3) scale = SW'(7);
         if (samples && k == p - 1) bus_in = ~busv;
         @(negedge clk);
         k++;
      end
      req_valid = 1'b0;
      check(lowc == lo, {req, " low phase cycles"}, lowc, lo);
      check(k == tot + 1, {req, " R9 done cycle"}, k, tot + 1);
      check(busy == 1'b0, {req, " R9 busy clear at done"}, busy, 0);
      if (samples) exp_rx = busv;
      check(rx_bit == exp_rx, {req, samples ? " R8 sampled value" : " R10 rx unchanged"},
            rx_bit, exp_rx);
      bus_in = 1'b1;
      @(negedge clk);
      check(done == 1'b0, {req, " R9 done one cycle"}, done, 0);
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(pull_low == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 outputs idle",
            {pull_low, busy, done}, 0);
      check(rx_bit == 1'b1, "R1 rx reset value", rx_bit, 1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: kind 11 starts nothing
      req_valid = 1'b1; req_kind = 2'b11;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && pull_low == 1'b0, "R2 kind 11 ignored", {busy, pull_low}, 0);

      for (int sc = 0; sc <= 3; sc++) begin
         run_slot(2'b00, 1'b1, sc, 1'b1, 0, "R3 R7 write1");
         run_slot(2'b00, 1'b0, sc, 1'b1, 0, "R4 R7 write0");
         for (int bv = 0; bv < 2; bv++) begin
            run_slot(2'b01, 1'(bv), sc, 1'(bv), 0, "R5 R7 read");
            run_slot(2'b00, 1'b1, sc, 1'(~bv), 0, "R10 write after read");
         end
      end
      for (int sc = 1; sc <= 3; sc++) begin
         for (int bv = 0; bv < 2; bv++) begin
            run_slot(2'b10, 1'b0, sc, 1'(bv), 0, "R6 R7 reset");
         end
      end
      run_slot(2'b10, 1'b0, 7, 1'b0, 0, "R6 R7 reset max scale");
      run_slot(2'b01, 1'b0, 2, 1'b0, 1, "R9 read with busy request");
      run_slot(2'b00, 1'b0, 1, 1'b1, 1, "R9 write0 with busy request");
      run_slot(2'b01, 1'b1, 1, 1'b1, 2, "R7 read scale change");
      run_slot(2'b00, 1'b1, 2, 1'b0, 2, "R7 write1 scale change");
      repeat (5) @(negedge clk);
      check(busy == 1'b0 && pull_low == 1'b0, "R11 idle after runs", {busy, pull_low}, 0);
      report();
   end

endmodule